// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous binary up-counter built from 4-bit stages, each of which counts modulo sixteen. Every stage updates on the rising clock edge. An active-low clear forces the whole count to zero at once, without waiting for the clock. An active-low load copies the data inputs into the count at the next rising edge, and it overrides both count enables. The count advances only when both enables are high. If either enable is low, the count holds.

The two enables do different jobs. The shared enable (`en_p`) only gates counting. The carry enable (`en_t`) gates counting and also the terminal-count output. `tc` is high only when the carry enable is high and the count is all ones.

A `STAGES` parameter chains several 4-bit stages into one wider counter. Inside the chain, the terminal count of each stage drives the carry enable of the next stage. The load, the shared enable and the clock are common to every stage. All stages are clocked together, so the chain behaves as a single counter of width 4×`STAGES`.

Top module: `casc_bin_counter`

## Requirements
- R1: With `clr_n`, `load_n`, `en_p` and `en_t` all high at a rising edge, `q` becomes its previous value plus one.
- R2: While `clr_n` is low, `q` is zero and `tc` is low. The clear acts without a clock edge, whatever the levels on `load_n`, `en_p`, `en_t` and `data`.
- R3: With `clr_n` high and `load_n` low at a rising edge, `q` takes the value on `data`, whatever the levels on `en_p` and `en_t`.
- R4: With `clr_n` and `load_n` high and either `en_p` or `en_t` low at a rising edge, `q` keeps its value.
- R5: Counting from all ones wraps to zero. This holds for the whole width and for the low 4-bit stage on its own.
- R6: `tc` is high exactly when `en_t` is high and every bit of `q` is one. It follows `en_t` combinationally, within the same cycle.
- R7: In a chain, bits 4s+3..4s form stage s, with stage 0 the least significant. Stage s advances only when `en_p` is high and `en_t` is high and every lower stage is at fifteen, so a carry passes into the next stage on the same edge that the lower stage wraps.
- R8: Only `en_t` gates `tc`. With the count at all ones and `en_t` high, `tc` stays high while `en_p` is low.
- R9: A clear takes priority over a load. If `clr_n` and `load_n` are both low, `q` stays zero across the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Shared count enable |
| en_t | input | 1 | Carry enable; also gates `tc` |
| data | input | 4*STAGES | Parallel load value |
| q | output | 4*STAGES | Count value |
| tc | output | 1 | Terminal count, high when `en_t` is high and `q` is all ones |

## Verification
The bench builds two copies of the block from the same control stimulus.

- A single stage (`STAGES=1`) makes wrap-around and the `tc` gating reachable within a few cycles.
- A three-stage chain (`STAGES=3`, 12 bits) is loaded close to stage boundaries. This exercises carries out of the first and second stages, and a wrap of the full width from 0xFFF to 0x000.

Directed sequences cover the load of twelve followed by counting, the holds set up by each enable alone, and the combined clear and load. A run of random control patterns follows.

// File: rtl/casc_bin_counter.sv
module casc_bin_counter #(
  parameter int STAGES = 1
) (
  input  logic                  clk,
  input  logic                  clr_n,
  input  logic                  load_n,
  input  logic                  en_p,
  input  logic                  en_t,
  input  logic [4*STAGES-1:0]   data,
  output logic [4*STAGES-1:0]   q,
  output logic                  tc
);
  localparam int W = 4 * STAGES;

  logic [STAGES:0] carry;
  assign carry[0] = en_t;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [3:0] cnt;

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                cnt <= 4'd0;
      else if (!load_n)          cnt <= data[4*s +: 4];
      else if (en_p && carry[s]) cnt <= cnt + 4'd1;
    end

    assign carry[s+1] = carry[s] & (&cnt);
    assign q[4*s +: 4] = cnt;
  end

  assign tc = carry[STAGES];

endmodule

module casc_bin_counter_chk #(
  parameter int STAGES = 1
) (
  input logic                clk,
  input logic                clr_n,
  input logic                load_n,
  input logic                en_p,
  input logic                en_t,
  input logic [4*STAGES-1:0] data,
  input logic [4*STAGES-1:0] q,
  input logic                tc
);
  localparam int W = 4 * STAGES;

  // R2
  always @(posedge clk) if (!clr_n) clear_zero_chk: assert (q == '0 && !tc);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> (q == W'($past(q) + 1'b1)));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!load_n) |=> (q == $past(data)));

  // R4
  hold_value_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  // R5
  low_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t && (&q[3:0])) |=> (q[3:0] == 4'd0));

  // R6
  tc_high_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (en_t && (&q)) |-> tc);

  // R6
  tc_only_full_chk: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> (en_t && (&q)));
endmodule

bind casc_bin_counter casc_bin_counter_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
  .data(data), .q(q), .tc(tc)
);

// File: tb/sim_casc_bin_counter.sv
module sim_casc_bin_counter;
  logic clk = 1'b0;
  logic clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0]  d0 = '0;
  logic [11:0] d1 = '0;
  logic [3:0]  q0;
  logic [11:0] q1;
  logic tc0, tc1;

  int checks = 0, failures = 0;
  int m0 = 0, m1 = 0;
  logic [17:0] exp_q[$];
  string       exp_tag[$];
  bit          done = 0;

  always #5 clk = ~clk;

  casc_bin_counter #(.STAGES(1)) u0 (.clk(clk), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .data(d0), .q(q0), .tc(tc0));
  casc_bin_counter #(.STAGES(3)) u1 (.clk(clk), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .data(d1), .q(q1), .tc(tc1));

  function automatic logic [17:0] pack_now();
    return {12'(m1), 1'(en_t && m1 == 4095), 4'(m0), 1'(en_t && m0 == 15)};
  endfunction

  task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: q1=%h tc1=%b q0=%h tc0=%b, expected q1=%h tc1=%b q0=%h tc0=%b",
               tag, act[17:6], act[5], act[4:1], act[0],
               exp[17:6], exp[5], exp[4:1], exp[0]);
    end
  endtask

  task automatic cycle(string tag, bit c, bit l, bit p, bit t, logic [3:0] a, logic [11:0] b);
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t = t; d0 = a; d1 = b;
    if (!c) begin m0 = 0; m1 = 0; end
    else if (!l) begin m0 = a; m1 = b; end
    else if (p && t) begin m0 = (m0 + 1) % 16; m1 = (m1 + 1) % 4096; end
    exp_q.push_back(pack_now());
    exp_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(exp_tag.pop_front(), {q1, tc1, q0, tc0}, exp_q.pop_front());
  end

  initial begin
    #1 clr_n = 1'b0;
    #2 check("R2 reset", {q1, tc1, q0, tc0}, 18'd0);
    cycle("R2 reset held", 0, 1, 1, 1, 4'h0, 12'h0);
    // load twelve, then count through the wrap
    cycle("R3 load", 1, 0, 0, 0, 4'hC, 12'hFFC);
    for (int i = 0; i < 6; i++) cycle("R1 R5 R7 count/wrap", 1, 1, 1, 1, 4'h0, 12'h0);
    cycle("R4 hold en_p low", 1, 1, 0, 1, 4'h0, 12'h0);
    cycle("R4 hold en_t low", 1, 1, 1, 0, 4'h0, 12'h0);
    // load with both enables high: load wins
    cycle("R3 load over enables", 1, 0, 1, 1, 4'hE, 12'h0FE);
    for (int i = 0; i < 3; i++) cycle("R7 stage carry", 1, 1, 1, 1, 4'h0, 12'h0);
    cycle("R3 load ones", 1, 0, 0, 1, 4'hF, 12'hFFF);
    cycle("R8 tc with en_p low", 1, 1, 0, 1, 4'h0, 12'h0);
    // tc follows en_t within the cycle
    @(negedge clk); en_t = 1'b0; m0 = m0;
    #1 check("R6 tc drops with en_t", {q1, tc1, q0, tc0}, {12'hFFF, 1'b0, 4'hF, 1'b0});
    en_t = 1'b1;
    #1 check("R6 tc rises with en_t", {q1, tc1, q0, tc0}, {12'hFFF, 1'b1, 4'hF, 1'b1});
    // clear asserted with load, between edges
    @(posedge clk); #2;
    clr_n = 1'b0; load_n = 1'b0; d0 = 4'h9; d1 = 12'h9A5; m0 = 0; m1 = 0;
    #1 check("R2 async clear", {q1, tc1, q0, tc0}, 18'd0);
    cycle("R9 clear over load", 0, 0, 1, 1, 4'h9, 12'h9A5);
    cycle("R3 load after clear", 1, 0, 1, 1, 4'h3, 12'h7F3);
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r = $urandom;
      cycle("R1 R3 R4 random", 1, r[0] | r[1] | r[2], r[3] | r[4], r[5] | r[6], r[11:8], r[23:12]);
    end
    cycle("R4 idle", 1, 1, 0, 0, 4'h0, 12'h0);
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule